// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running nanosecond time of day for packet timestamping. Its accumulator has a 64-bit whole-nanosecond part and a 32-bit sub-nanosecond part. On every core clock cycle that the counter is enabled, a programmable increment in 32.32 fixed-point nanoseconds is added to it. The fractional increment lets software trim the rate in steps far finer than one nanosecond per cycle, where a plain tick counter can only step in whole units.

After reset a small initialisation state machine works out the default increment from the core clock rate. The core clock is 50 MHz times a 6-bit multiplier taken from a boot-strap word, so the default is (10^9 * 2^32) / (50e6 * m), which equals (20 * 2^32) / m. The state machine has four states. ST_LATCH captures the multiplier and goes to ST_DIVIDE. ST_DIVIDE runs one restoring-division step per cycle and goes to ST_PUBLISH after the last quotient bit. ST_PUBLISH copies the quotient into the increment register and goes to ST_DONE. ST_DONE is terminal and raises `init_done`.

Software uses a word-addressed register port. There is a control word with the enable bit, a fraction word, a whole-nanosecond word and an increment word.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the enable is 0 and both accumulator parts read 0. `init_done` rises once the initialisation state machine reaches ST_DONE.
- R2: Once `init_done` is 1, the increment register holds floor(20 * 2^32 / m). Here m is `strap_word[38:33]` when `strap_valid` is 1 and that field is nonzero. Otherwise m is 16.
- R3: While `init_done` is 0, register writes are ignored. The enable stays 0 and the increment stays at the derived default.
- R4: While enabled, each clock edge adds the zero-extended 64-bit increment to the 96-bit value {ns, frac}. A carry out of the fraction reaches the whole-nanosecond part in the same cycle.
- R5: Writing address 0 sets the enable from `reg_wdata[0]`. While the enable is 0 the accumulator holds its value.
- R6: Writing address 3 loads the increment. The addition at the edge of the write still uses the old increment, and the new increment is used from the following edge on. The accumulator is not cleared by this write.
- R7: Writing address 2 loads the whole-nanosecond part from `reg_wdata` and clears the fraction. This load takes priority over that cycle's addition. The whole-nanosecond part wraps modulo 2^64.
- R8: A read pulse at an edge puts the addressed word on `reg_rdata` at that edge. Address 0 returns {63'b0, enable}, address 1 the fraction shadow zero-extended, address 2 the whole nanoseconds, and address 3 the increment. A read of address 2 copies the live fraction into the shadow at the same edge, so a later read of address 1 matches that nanosecond value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_word | input | 64 | Boot-strap word carrying the clock multiplier in bits 38:33 |
| strap_valid | input | 1 | Strap word is available |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 fraction, 2 nanoseconds, 3 increment |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| init_done | output | 1 | Default increment derived and register writes accepted |

## Verification
All strobes and registers are updated at the same rising edge. A write at edge k changes the enable, the increment or the nanosecond value at edge k. A read at edge k presents its word on `reg_rdata` right after edge k. A new increment first contributes at edge k+1, and a newly set enable first adds at edge k+1. The bench drives each strobe for one full cycle starting at a falling edge and samples `reg_rdata` at the next falling edge. It also counts the exact number of edges that see the enable high, so every expected time is the product of the increment and that count, computed in 96-bit arithmetic. `init_done` is polled at falling edges after reset, because the division takes a fixed but parameter-dependent number of cycles.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    typedef enum logic [1:0] {
        ST_LATCH   = 2'd0,
        ST_DIVIDE  = 2'd1,
        ST_PUBLISH = 2'd2,
        ST_DONE    = 2'd3
    } init_st_e;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_FRAC = 2'd1,
        A_NS   = 2'd2,
        A_INCR = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ptp_incr_init.sv
module ptp_incr_init
    import ptp_tod_pkg::*;
#(
    parameter int BASE_RATIO   = 20,
    parameter int FRAC_W       = 32,
    parameter int MULT_W       = 6,
    parameter int MULT_LSB     = 33,
    parameter int DEFAULT_MULT = 16,
    parameter int INC_W        = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      strap_word,
    input  logic             strap_valid,
    output logic             publish,
    output logic             done,
    output logic [INC_W-1:0] incr_default
);
    localparam int DVD_W = $clog2(BASE_RATIO + 1) + FRAC_W;
    localparam int CNT_W = $clog2(DVD_W + 1);
    localparam int PRD_W = DVD_W + MULT_W;
    localparam logic [DVD_W-1:0] DVD_INIT = DVD_W'(BASE_RATIO) << FRAC_W;

    init_st_e          st_q, st_d;
    logic [MULT_W-1:0] div_q, rem_q, mult_sel;
    logic [DVD_W-1:0]  dvd_q, quo_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [MULT_W:0]   rem_sh;
    logic              q_bit;

    assign mult_sel = (strap_valid && strap_word[MULT_LSB +: MULT_W] != '0)
                      ? strap_word[MULT_LSB +: MULT_W] : MULT_W'(DEFAULT_MULT);
    assign rem_sh   = {rem_q, dvd_q[DVD_W-1]};
    assign q_bit    = rem_sh >= {1'b0, div_q};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LATCH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LATCH:   st_d = ST_DIVIDE;
            ST_DIVIDE:  if (cnt_q == CNT_W'(DVD_W - 1)) st_d = ST_PUBLISH;
            ST_PUBLISH: st_d = ST_DONE;
            ST_DONE:    st_d = ST_DONE;
        endcase
    end

    // division datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0; rem_q <= '0; dvd_q <= '0; quo_q <= '0; cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_LATCH: begin
                    div_q <= mult_sel;
                    dvd_q <= DVD_INIT;
                    rem_q <= '0;
                    quo_q <= '0;
                    cnt_q <= '0;
                end
                ST_DIVIDE: begin
                    rem_q <= q_bit ? MULT_W'(rem_sh - {1'b0, div_q}) : rem_sh[MULT_W-1:0];
                    quo_q <= {quo_q[DVD_W-2:0], q_bit};
                    dvd_q <= dvd_q << 1;
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        publish      = (st_q == ST_PUBLISH);
        done         = (st_q == ST_DONE);
        incr_default = INC_W'(quo_q);
    end

    p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_quotient_r2: assert property (@(posedge clk) disable iff (!rst_n)
        publish |-> ((PRD_W'(quo_q) * PRD_W'(div_q) <= PRD_W'(DVD_INIT)) &&
                     (PRD_W'(DVD_INIT) - PRD_W'(quo_q) * PRD_W'(div_q) < PRD_W'(div_q))));
endmodule

// File: rtl/ptp_accum.sv
module ptp_accum #(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int INC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ld,
    input  logic [NS_W-1:0]   ld_ns,
    input  logic [INC_W-1:0]  incr,
    output logic [NS_W-1:0]   ns,
    output logic [FRAC_W-1:0] frac
);
    localparam int ACC_W = NS_W + FRAC_W;

    logic [ACC_W-1:0] sum;
    assign sum = {ns, frac} + ACC_W'(incr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns   <= '0;
            frac <= '0;
        end else if (ld) begin
            ns   <= ld_ns;
            frac <= '0;
        end else if (en) begin
            {ns, frac} <= sum;
        end
    end

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld) |=> {ns, frac} == $past({ns, frac}) + ACC_W'($past(incr)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld) |=> $stable({ns, frac}));
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (ns == $past(ld_ns)) && (frac == '0));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int NS_W         = 64,
    parameter int FRAC_W       = 32,
    parameter int INT_INC_W    = 32,
    parameter int MULT_W       = 6,
    parameter int MULT_LSB     = 33,
    parameter int DEFAULT_MULT = 16,
    parameter int BASE_RATIO   = 20,
    parameter int DATA_W       = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       strap_word,
    input  logic              strap_valid,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              init_done
);
    localparam int INC_W = INT_INC_W + FRAC_W;

    logic [INC_W-1:0]  incr_q, incr_default;
    logic [NS_W-1:0]   acc_ns;
    logic [FRAC_W-1:0] acc_frac, shadow_q;
    logic              en_q, publish, wr_ok;
    reg_addr_e         addr;

    assign addr  = reg_addr_e'(reg_addr);
    assign wr_ok = reg_wr && init_done;

    ptp_incr_init #(
        .BASE_RATIO(BASE_RATIO), .FRAC_W(FRAC_W), .MULT_W(MULT_W),
        .MULT_LSB(MULT_LSB), .DEFAULT_MULT(DEFAULT_MULT), .INC_W(INC_W)
    ) u_init (
        .clk(clk), .rst_n(rst_n), .strap_word(strap_word), .strap_valid(strap_valid),
        .publish(publish), .done(init_done), .incr_default(incr_default)
    );

    ptp_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .ld(wr_ok && addr == A_NS), .ld_ns(NS_W'(reg_wdata)),
        .incr(incr_q), .ns(acc_ns), .frac(acc_frac)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            incr_q <= '0;
        end else begin
            if (publish)                     incr_q <= incr_default;
            else if (wr_ok && addr == A_INCR) incr_q <= INC_W'(reg_wdata);
            if (wr_ok && addr == A_CTRL)     en_q   <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (addr)
                A_CTRL: reg_rdata <= DATA_W'(en_q);
                A_FRAC: reg_rdata <= DATA_W'(shadow_q);
                A_NS: begin
                    reg_rdata <= DATA_W'(acc_ns);
                    shadow_q  <= acc_frac;
                end
                A_INCR: reg_rdata <= DATA_W'(incr_q);
            endcase
        end
    end

    p_no_enable_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !en_q);
    p_incr_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !(wr_ok && addr == A_INCR)) |=> $stable(incr_q));
    p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && addr == A_NS) |=> (shadow_q == $past(acc_frac)) &&
                                     (reg_rdata == DATA_W'($past(acc_ns))));
endmodule

// File: tb/tb_ptp_tod_counter.sv
module tb_ptp_tod_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] strap_word = '0;
    logic        strap_valid = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        init_done;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    localparam logic [1:0] CTRL = 2'd0, FRAC = 2'd1, NSR = 2'd2, INCR = 2'd3;

    ptp_tod_counter dut (
        .clk(clk), .rst_n(rst_n), .strap_word(strap_word), .strap_valid(strap_valid),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .init_done(init_done)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [63:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic do_reset(bit v, int m);
        @(negedge clk);
        rst_n = 1'b0; strap_valid = v; strap_word = 64'(m) << 33;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
    endtask

    function automatic logic [63:0] dflt(int m);
        logic [95:0] n = 96'd20 << 32;
        return 64'(n / 96'(m));
    endfunction

    task automatic t_reset_r1();
        logic [63:0] d;
        do_reset(0, 0);
        rd(CTRL, d); check("R1 enable after reset", d, 64'd0);
        rd(NSR, d);  check("R1 ns after reset", d, 64'd0);
        rd(FRAC, d); check("R1 frac after reset", d, 64'd0);
        wait_done();
        check("R1 init_done rises", 64'(init_done), 64'd1);
    endtask

    task automatic t_default_r2(bit v, int m, int eff);
        logic [63:0] d;
        do_reset(v, m);
        wait_done();
        rd(INCR, d);
        check($sformatf("R2 default incr m=%0d valid=%0d", m, v), d, dflt(eff));
    endtask

    task automatic t_gate_r3();
        logic [63:0] d;
        do_reset(1, 3);
        wr(INCR, 64'h1234);
        wr(CTRL, 64'd1);
        wr(NSR, 64'd99);
        wait_done();
        rd(INCR, d); check("R3 incr write ignored in init", d, dflt(3));
        rd(CTRL, d); check("R3 enable write ignored in init", d, 64'd0);
        rd(NSR, d);  check("R3 ns write ignored in init", d, 64'd0);
    endtask

    // run for exactly k adding edges (k >= 1)
    task automatic run(int k);
        wr(CTRL, 64'd1);
        repeat (k - 1) @(negedge clk);
        wr(CTRL, 64'd0);
    endtask

    task automatic t_accum_r4(int m, int k);
        logic [63:0] d;
        logic [95:0] e;
        do_reset(1, m);
        wait_done();
        wr(NSR, 64'd0);
        run(k);
        e = 96'(k) * 96'(dflt(m));
        rd(NSR, d);  check($sformatf("R4 ns after %0d adds m=%0d", k, m), d, e[95:32]);
        rd(FRAC, d); check($sformatf("R4 frac after %0d adds m=%0d", k, m), d, 64'(e[31:0]));
    endtask

    task automatic t_hold_r5();
        logic [63:0] a, b;
        rd(NSR, a);
        repeat (10) @(negedge clk);
        rd(NSR, b);
        check("R5 ns held while disabled", b, a);
        rd(CTRL, b); check("R5 enable reads back 0", b, 64'd0);
    endtask

    task automatic t_incr_r6();
        logic [63:0] d, oldi;
        logic [95:0] e;
        logic [63:0] newi = 64'h2_4000_0000;
        do_reset(0, 0);
        wait_done();
        oldi = dflt(16);
        wr(NSR, 64'd0);
        wr(CTRL, 64'd1);
        wr(INCR, newi);
        wr(CTRL, 64'd0);
        e = 96'(oldi) + 96'(newi);
        rd(NSR, d);  check("R6 old then new incr ns", d, e[95:32]);
        rd(FRAC, d); check("R6 old then new incr frac", d, 64'(e[31:0]));
        rd(INCR, d); check("R6 incr reads back", d, newi);
    endtask

    task automatic t_wrap_r7();
        logic [63:0] d;
        wr(INCR, 64'h3_0000_0000);
        wr(NSR, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(NSR, d); check("R7 ns load", d, 64'hFFFF_FFFF_FFFF_FFFE);
        run(1);
        rd(NSR, d);  check("R7 ns wraps mod 2^64", d, 64'd1);
        rd(FRAC, d); check("R7 frac cleared by load", d, 64'd0);
    endtask

    task automatic t_shadow_r8();
        logic [63:0] n, f;
        wr(INCR, 64'h1_8000_0000);
        wr(NSR, 64'd0);
        wr(CTRL, 64'd1);
        repeat (5) @(negedge clk);
        rd(NSR, n);
        rd(FRAC, f);
        wr(CTRL, 64'd0);
        check("R8 shadow frac coherent with ns", f,
              (n % 3 == 1) ? 64'h8000_0000 : 64'd0);
    endtask

    initial begin
        t_reset_r1();
        t_default_r2(0, 0, 16);
        t_default_r2(1, 3, 3);
        t_default_r2(1, 20, 20);
        t_default_r2(1, 0, 16);
        t_gate_r3();
        t_accum_r4(16, 8);
        t_accum_r4(3, 3);
        t_hold_r5();
        t_incr_r6();
        t_wrap_r7();
        t_shadow_r8();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule